// File: doc/BRIEF.md
# Execution-Cycle Bus Control Generator

This block turns the current machine-cycle kind, the timing pulse and the opcode held in the first instruction latch into the enable and clock controls of a small 8-bit CPU. That CPU has one 8-bit data bus and one 16-bit address bus. In every cycle it picks at most one source for each bus: the program counter, the HL pair, instruction bytes 2 and 3, or the incrementer's up or down output for the address bus, and RAM, the register array, the accumulator, instruction byte 2 or the ALU result for the data bus. The load strobes that capture the bus value are raised only while the pulse is high.

Fetch cycles read instruction bytes at the program counter. Increment cycles write the bumped address back into the program counter. In the one or two execution cycles, a per-instruction table sets the controls for register moves, immediate loads, arithmetic, direct loads and stores, and HL increment or decrement. An operand code of 110 means the memory byte that HL addresses, so HL drives the address bus and RAM takes the place of the register array. All outputs are registered: each output reflects the inputs sampled at the previous rising clock edge.

Top module: `cyc_ctl_matrix`

## Requirements
- R1: While `rst` is high at a rising edge, all of `addr_drv`, `data_drv` and `load_stb` are zero after that edge.
- R2: The outputs change only at a rising edge and reflect the inputs sampled at that edge, so they have one cycle of latency.
- R3: `cyc_kind` 1, 2 or 3 (fetch of byte 1, 2 or 3) sets `addr_drv[0]` (program counter) and `data_drv[0]` (RAM). With pulse high it also sets `load_stb[4]` (incrementer latch) and `load_stb[7]`, `[8]` or `[9]` (instruction latch 1, 2 or 3).
- R4: `cyc_kind` 4 (counter increment) sets `addr_drv[3]` (incremented value). With pulse high it also sets `load_stb[6]` (program counter).
- R5: At most one bit of `addr_drv` and at most one bit of `data_drv` is set in any cycle.
- R6: No bit of `load_stb` is set unless `pulse` was high at the sampling edge. Drivers do not depend on `pulse`.
- R7: In execute 1 (`cyc_kind` 5), a move `01dddsss` (not 0x76) drives the register array (`data_drv[1]`) or RAM (`data_drv[0]`) when sss is 110. It loads the register array (`load_stb[0]`) or writes RAM (`load_stb[5]`) when ddd is 110. Any memory operand sets `addr_drv[1]` (HL).
- R8: In execute 1, an immediate move `00ddd110` drives instruction byte 2 (`data_drv[3]`) and loads the register array, or, when ddd is 110, sets HL on the address bus and writes RAM.
- R9: Arithmetic `10fffsss` in execute 1 drives the register array, or HL with RAM when sss is 110. Immediate arithmetic `11fff110` drives byte 2. Either form strobes the ALU latch (`load_stb[2]`). In execute 2 (`cyc_kind` 6) both forms drive the ALU (`data_drv[4]`) and load the accumulator (`load_stb[1]`).
- R10: In execute 1, load-direct 0x3A sets `addr_drv[2]` (instruction bytes 2–3), drives RAM and loads the accumulator. Store-direct 0x32 sets `addr_drv[2]`, drives the accumulator (`data_drv[2]`) and writes RAM.
- R11: HL increment 0x23 and decrement 0x2B set HL on the address bus and strobe the incrementer latch in execute 1. In execute 2 they set `addr_drv[3]` (0x23) or `addr_drv[4]` (0x2B) and strobe HL (`load_stb[3]`).
- R12: NOP 0x00, HLT 0x76, any opcode not listed above, execute 2 of a single-execute instruction, and `cyc_kind` 0 or 7 all give zero on every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_kind | input | 3 | Cycle kind: 0/7 idle, 1–3 fetch byte n, 4 counter increment, 5 execute 1, 6 execute 2 |
| pulse | input | 1 | Strobe window within the cycle |
| opcode | input | 8 | Opcode from instruction latch 1 |
| addr_drv | output | 5 | Address-bus source: [0] PC, [1] HL, [2] bytes 2–3, [3] incremented, [4] decremented |
| data_drv | output | 5 | Data-bus source: [0] RAM, [1] register array, [2] accumulator, [3] byte 2, [4] ALU |
| load_stb | output | 10 | [0] reg array, [1] acc, [2] ALU latch, [3] HL, [4] inc/dec latch, [5] RAM write, [6] PC, [7..9] instr latch 1..3 |

## Verification
The checker watches several properties on every clock cycle. It checks that each bus has a single driver, that no strobe appears without a pulse, that reset clears the outputs, and that fetch, increment and idle cycle kinds produce their fixed drivers. The per-opcode contents of the execution table are checked only by the bench's scenarios. These cover register versus memory operands, immediate forms, direct loads and stores, and the two-step HL update. The bench scenarios also show the one-cycle latency and the silence on NOP, HLT and unlisted codes.

// File: rtl/ctlmx_pkg.sv
package ctlmx_pkg;
  localparam int NUM_FETCH = 3;
  localparam int ABUS_W    = 5;
  localparam int DBUS_W    = 5;
  localparam int STB_BASE  = 7;
  localparam int STB_W     = STB_BASE + NUM_FETCH;
  localparam int CK_W      = 3;
  localparam int OP_W      = 8;

  // address-bus source positions
  localparam int A_PC  = 0;
  localparam int A_HL  = 1;
  localparam int A_IB  = 2;
  localparam int A_INC = 3;
  localparam int A_DEC = 4;

  // data-bus source positions
  localparam int D_RAM = 0;
  localparam int D_RA  = 1;
  localparam int D_ACC = 2;
  localparam int D_IMM = 3;
  localparam int D_ALU = 4;

  // load strobe positions
  localparam int S_RA  = 0;
  localparam int S_ACC = 1;
  localparam int S_ALU = 2;
  localparam int S_HL  = 3;
  localparam int S_ID  = 4;
  localparam int S_WR  = 5;
  localparam int S_PC  = 6;
  localparam int S_IL0 = STB_BASE;

  localparam logic [2:0] MEM_CODE = 3'b110;

  localparam logic [CK_W-1:0] CK_F1    = 3'd1;
  localparam logic [CK_W-1:0] CK_PCINC = 3'd4;
  localparam logic [CK_W-1:0] CK_EX1   = 3'd5;
  localparam logic [CK_W-1:0] CK_EX2   = 3'd6;

  localparam logic [OP_W-1:0] OP_LDA = 8'h3A;
  localparam logic [OP_W-1:0] OP_STA = 8'h32;
  localparam logic [OP_W-1:0] OP_INX = 8'h23;
  localparam logic [OP_W-1:0] OP_DCX = 8'h2B;

  typedef struct packed {
    logic mov;
    logic mvi;
    logic alu_reg;
    logic alu_imm;
    logic lda;
    logic sta;
    logic inx;
    logic dcx;
    logic hlt;
    logic src_mem;
    logic dst_mem;
  } op_class_t;
endpackage

// File: rtl/ctlmx_decode.sv
module ctlmx_decode
  import ctlmx_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output op_class_t       cls
);
  logic [1:0] grp;
  logic [2:0] dst;
  logic [2:0] src;

  assign grp = opcode[7:6];
  assign dst = opcode[5:3];
  assign src = opcode[2:0];

  always_comb begin
    cls = '0;
    unique case (grp)
      2'b00: begin
        if (src == MEM_CODE)    cls.mvi = 1'b1;
        else if (opcode == OP_LDA) cls.lda = 1'b1;
        else if (opcode == OP_STA) cls.sta = 1'b1;
        else if (opcode == OP_INX) cls.inx = 1'b1;
        else if (opcode == OP_DCX) cls.dcx = 1'b1;
      end
      2'b01: begin
        if (dst == MEM_CODE && src == MEM_CODE) cls.hlt = 1'b1;
        else                                    cls.mov = 1'b1;
      end
      2'b10: cls.alu_reg = 1'b1;
      2'b11: cls.alu_imm = (src == MEM_CODE);
      default: ;
    endcase
    cls.src_mem = (cls.mov | cls.alu_reg) & (src == MEM_CODE);
    cls.dst_mem = (cls.mov | cls.mvi) & (dst == MEM_CODE);
  end
endmodule

// File: rtl/ctlmx_fetch.sv
module ctlmx_fetch
  import ctlmx_pkg::*;
#(
  parameter int FETCHES = NUM_FETCH
) (
  input  logic [CK_W-1:0]   ck,
  input  logic              pulse,
  output logic [ABUS_W-1:0] addr_sel,
  output logic [DBUS_W-1:0] data_sel,
  output logic [STB_W-1:0]  stb
);
  logic [FETCHES-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < FETCHES; g++) begin : g_fetch
      localparam logic [CK_W-1:0] CODE = CK_W'(int'(CK_F1) + g);
      assign hit[g] = (ck == CODE);
    end
  endgenerate

  logic any_fetch;
  logic inc_cyc;
  assign any_fetch = |hit;
  assign inc_cyc   = (ck == CK_PCINC);

  always_comb begin
    addr_sel = '0;
    data_sel = '0;
    stb      = '0;
    if (any_fetch) begin
      addr_sel[A_PC]  = 1'b1;
      data_sel[D_RAM] = 1'b1;
      stb[S_ID]       = pulse;
      stb[S_IL0 +: FETCHES] = hit & {FETCHES{pulse}};
    end
    if (inc_cyc) begin
      addr_sel[A_INC] = 1'b1;
      stb[S_PC]       = pulse;
    end
  end
endmodule

// File: rtl/ctlmx_exec.sv
module ctlmx_exec
  import ctlmx_pkg::*;
(
  input  logic [CK_W-1:0]   ck,
  input  logic              pulse,
  input  op_class_t         cls,
  output logic [ABUS_W-1:0] addr_sel,
  output logic [DBUS_W-1:0] data_sel,
  output logic [STB_W-1:0]  stb
);
  logic ex1;
  logic ex2;
  logic [STB_W-1:0] stb_raw;

  assign ex1 = (ck == CK_EX1);
  assign ex2 = (ck == CK_EX2);

  always_comb begin
    addr_sel = '0;
    data_sel = '0;
    stb_raw  = '0;
    if (ex1) begin
      if (cls.mov) begin
        if (cls.src_mem) data_sel[D_RAM] = 1'b1;
        else             data_sel[D_RA]  = 1'b1;
        if (cls.dst_mem) stb_raw[S_WR]   = 1'b1;
        else             stb_raw[S_RA]   = 1'b1;
        if (cls.src_mem | cls.dst_mem) addr_sel[A_HL] = 1'b1;
      end
      if (cls.mvi) begin
        data_sel[D_IMM] = 1'b1;
        if (cls.dst_mem) begin
          addr_sel[A_HL] = 1'b1;
          stb_raw[S_WR]  = 1'b1;
        end else begin
          stb_raw[S_RA]  = 1'b1;
        end
      end
      if (cls.alu_reg) begin
        if (cls.src_mem) begin
          addr_sel[A_HL]  = 1'b1;
          data_sel[D_RAM] = 1'b1;
        end else begin
          data_sel[D_RA]  = 1'b1;
        end
        stb_raw[S_ALU] = 1'b1;
      end
      if (cls.alu_imm) begin
        data_sel[D_IMM] = 1'b1;
        stb_raw[S_ALU]  = 1'b1;
      end
      if (cls.lda) begin
        addr_sel[A_IB]  = 1'b1;
        data_sel[D_RAM] = 1'b1;
        stb_raw[S_ACC]  = 1'b1;
      end
      if (cls.sta) begin
        addr_sel[A_IB]  = 1'b1;
        data_sel[D_ACC] = 1'b1;
        stb_raw[S_WR]   = 1'b1;
      end
      if (cls.inx | cls.dcx) begin
        addr_sel[A_HL] = 1'b1;
        stb_raw[S_ID]  = 1'b1;
      end
    end
    if (ex2) begin
      if (cls.alu_reg | cls.alu_imm) begin
        data_sel[D_ALU] = 1'b1;
        stb_raw[S_ACC]  = 1'b1;
      end
      if (cls.inx) begin
        addr_sel[A_INC] = 1'b1;
        stb_raw[S_HL]   = 1'b1;
      end
      if (cls.dcx) begin
        addr_sel[A_DEC] = 1'b1;
        stb_raw[S_HL]   = 1'b1;
      end
    end
  end

  assign stb = stb_raw & {STB_W{pulse}};
endmodule

// File: rtl/cyc_ctl_matrix.sv
module cyc_ctl_matrix
  import ctlmx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CK_W-1:0]   cyc_kind,
  input  logic              pulse,
  input  logic [OP_W-1:0]   opcode,
  output logic [ABUS_W-1:0] addr_drv,
  output logic [DBUS_W-1:0] data_drv,
  output logic [STB_W-1:0]  load_stb
);
  op_class_t         cls;
  logic [ABUS_W-1:0] f_addr, e_addr;
  logic [DBUS_W-1:0] f_data, e_data;
  logic [STB_W-1:0]  f_stb,  e_stb;

  ctlmx_decode u_dec (
    .opcode (opcode),
    .cls    (cls)
  );

  ctlmx_fetch #(.FETCHES(NUM_FETCH)) u_fetch (
    .ck       (cyc_kind),
    .pulse    (pulse),
    .addr_sel (f_addr),
    .data_sel (f_data),
    .stb      (f_stb)
  );

  ctlmx_exec u_exec (
    .ck       (cyc_kind),
    .pulse    (pulse),
    .cls      (cls),
    .addr_sel (e_addr),
    .data_sel (e_data),
    .stb      (e_stb)
  );

  // fetch and execute decode disjoint cycle kinds, so OR-merging is safe
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_drv <= '0;
      data_drv <= '0;
      load_stb <= '0;
    end else begin
      addr_drv <= f_addr | e_addr;
      data_drv <= f_data | e_data;
      load_stb <= f_stb  | e_stb;
    end
  end
endmodule

// File: rtl/ctlmx_chk.sv
module ctlmx_chk
  import ctlmx_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [CK_W-1:0]   cyc_kind,
  input logic              pulse,
  input logic [OP_W-1:0]   opcode,
  input logic [ABUS_W-1:0] addr_drv,
  input logic [DBUS_W-1:0] data_drv,
  input logic [STB_W-1:0]  load_stb
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (addr_drv == '0 && data_drv == '0 && load_stb == '0));

  a_r5_addr_single: assert property (@(posedge clk) disable iff (rst)
    $onehot0(addr_drv));

  a_r5_data_single: assert property (@(posedge clk) disable iff (rst)
    $onehot0(data_drv));

  a_r6_strobe_needs_pulse: assert property (@(posedge clk) disable iff (rst)
    (load_stb != '0) |-> $past(pulse));

  a_r3_fetch_drivers: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cyc_kind) >= 3'd1 && $past(cyc_kind) <= 3'd3)
      |-> (addr_drv[A_PC] && data_drv[D_RAM]));

  a_r4_inc_driver: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cyc_kind) == CK_PCINC)
      |-> (addr_drv[A_INC] && data_drv == '0));

  a_r12_idle_silent: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(cyc_kind) == 3'd0 || $past(cyc_kind) == 3'd7))
      |-> (addr_drv == '0 && data_drv == '0 && load_stb == '0));
endmodule

bind cyc_ctl_matrix ctlmx_chk u_chk (.*);

// File: tb/sim_cyc_ctl_matrix.sv
`timescale 1ns/1ps
module sim_cyc_ctl_matrix;
  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] cyc_kind;
  logic       pulse;
  logic [7:0] opcode;
  logic [4:0] addr_drv;
  logic [4:0] data_drv;
  logic [9:0] load_stb;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  cyc_ctl_matrix u0 (
    .clk(clk), .rst(rst), .cyc_kind(cyc_kind), .pulse(pulse), .opcode(opcode),
    .addr_drv(addr_drv), .data_drv(data_drv), .load_stb(load_stb)
  );

  localparam logic [4:0] A0 = 5'd0, APC = 5'b00001, AHL = 5'b00010, AIB = 5'b00100,
                         AIN = 5'b01000, ADE = 5'b10000;
  localparam logic [4:0] D0 = 5'd0, DRM = 5'b00001, DRA = 5'b00010, DAC = 5'b00100,
                         DIM = 5'b01000, DAL = 5'b10000;
  localparam logic [9:0] S0 = 10'd0, SRA = 10'd1, SAC = 10'd2, SAL = 10'd4, SHL = 10'd8,
                         SID = 10'd16, SWR = 10'd32, SPC = 10'd64,
                         SI1 = 10'd128, SI2 = 10'd256, SI3 = 10'd512;

  // {cyc_kind, pulse, opcode, addr, data, strobes}
  localparam int NV = 28;
  localparam logic [31:0] VEC [NV] = '{
    {3'd1, 1'b1, 8'h00, APC, DRM, SID|SI1},  // R3 fetch 1
    {3'd2, 1'b0, 8'h3E, APC, DRM, S0},       // R3 R6 fetch 2 no pulse
    {3'd2, 1'b1, 8'h3E, APC, DRM, SID|SI2},  // R3 fetch 2
    {3'd3, 1'b1, 8'h3A, APC, DRM, SID|SI3},  // R3 fetch 3
    {3'd4, 1'b1, 8'h3A, AIN, D0,  SPC},      // R4
    {3'd4, 1'b0, 8'h3A, AIN, D0,  S0},       // R4 R6
    {3'd5, 1'b1, 8'h78, A0,  DRA, SRA},      // R7 reg to reg
    {3'd5, 1'b1, 8'h7E, AHL, DRM, SRA},      // R7 mem source
    {3'd5, 1'b1, 8'h77, AHL, DRA, SWR},      // R7 mem dest
    {3'd5, 1'b0, 8'h77, AHL, DRA, S0},       // R7 R6
    {3'd5, 1'b1, 8'h3E, A0,  DIM, SRA},      // R8 to reg
    {3'd5, 1'b1, 8'h36, AHL, DIM, SWR},      // R8 to mem
    {3'd5, 1'b1, 8'h80, A0,  DRA, SAL},      // R9 reg
    {3'd5, 1'b1, 8'h86, AHL, DRM, SAL},      // R9 mem
    {3'd5, 1'b1, 8'hC6, A0,  DIM, SAL},      // R9 imm
    {3'd6, 1'b1, 8'hC6, A0,  DAL, SAC},      // R9 exec 2
    {3'd6, 1'b1, 8'h96, A0,  DAL, SAC},      // R9 exec 2 mem form
    {3'd5, 1'b1, 8'h3A, AIB, DRM, SAC},      // R10 load
    {3'd5, 1'b1, 8'h32, AIB, DAC, SWR},      // R10 store
    {3'd5, 1'b1, 8'h23, AHL, D0,  SID},      // R11 inc step 1
    {3'd6, 1'b1, 8'h23, AIN, D0,  SHL},      // R11 inc step 2
    {3'd6, 1'b1, 8'h2B, ADE, D0,  SHL},      // R11 dec step 2
    {3'd5, 1'b1, 8'h00, A0,  D0,  S0},       // R12 NOP
    {3'd5, 1'b1, 8'h76, A0,  D0,  S0},       // R12 HLT
    {3'd6, 1'b1, 8'h78, A0,  D0,  S0},       // R12 exec 2 single
    {3'd6, 1'b1, 8'h3A, A0,  D0,  S0},       // R12 exec 2 single
    {3'd0, 1'b1, 8'h7E, A0,  D0,  S0},       // R12 idle
    {3'd7, 1'b1, 8'h01, A0,  D0,  S0}        // R12 idle + unlisted
  };

  task automatic check(input string tag, input logic [4:0] ea, input logic [4:0] ed,
                       input logic [9:0] es);
    checks++;
    if (addr_drv !== ea || data_drv !== ed || load_stb !== es) begin
      errors++;
      $display("FAIL %s: got addr=%b data=%b stb=%b, expected addr=%b data=%b stb=%b",
               tag, addr_drv, data_drv, load_stb, ea, ed, es);
    end
  endtask

  task automatic drive(input logic [2:0] k, input logic p, input logic [7:0] op);
    cyc_kind = k;
    pulse    = p;
    opcode   = op;
  endtask

  initial begin
    rst = 1'b1;
    drive(3'd5, 1'b1, 8'h7E);
    repeat (3) @(negedge clk);
    check("R1 reset", A0, D0, S0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][31:29], VEC[i][28], VEC[i][27:20]);
      @(negedge clk);
      check($sformatf("vector %0d op=%h", i, VEC[i][27:20]),
            VEC[i][19:15], VEC[i][14:10], VEC[i][9:0]);
      checks++;
      if ($countones(addr_drv) > 1 || $countones(data_drv) > 1) begin
        errors++;
        $display("FAIL R5 vector %0d: addr=%b data=%b, expected at most one bit each",
                 i, addr_drv, data_drv);
      end
    end

    // R2: one cycle of latency
    drive(3'd1, 1'b1, 8'h00);
    @(negedge clk);
    drive(3'd0, 1'b0, 8'h00);
    #1;
    check("R2 holds until edge", APC, DRM, SID|SI1);
    @(negedge clk);
    check("R2 updates after edge", A0, D0, S0);

    // R1: reset mid-stream clears outputs
    drive(3'd4, 1'b1, 8'h00);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset mid-run", A0, D0, S0);
    rst = 1'b0;
    @(negedge clk);
    check("R4 after reset", AIN, D0, SPC);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule